// File: doc/BRIEF.md
# CRC-4 Multiframe Search Timeout Counter

This block sits beside an E1 receive synchronizer and measures how long the hunt for CRC-4 multiframe alignment has been running. While CRC-4 mode is on and the synchronizer reports an active CRC-4 search, the block counts frame strobes in fixed windows of 64 frames (8 ms at 125 µs per frame). Each time a window runs out before alignment is reached, a 6-bit window counter steps up by one. That counter stops at its ceiling and never wraps.

The count returns to zero when the synchronizer reports CRC-4 multiframe alignment. It is also held at zero for as long as CRC-4 mode is switched off. A flag rises once 50 windows (400 ms) have gone by, so that surrounding logic can give up the search.

The block also provides a live status byte. It combines five of the counter bits with the three search-active indications from the synchronizer. Counter bit 1 is left out of this byte, so the five reported bits still resolve beyond 400 ms.

Top module: `crc4_sync_timer`

## Requirements
- R1: While crc4_en_i is high, crc4_srch_i is high and no lock is reported, every 64th frame strobe completes a window, and count_o rises by one at the clock edge that samples that strobe.
- R2: A window starts when crc4_srch_i goes high. If crc4_srch_i drops mid-window, the partial window is discarded, so strobes counted before the drop never contribute to an expiry.
- R3: A high crc4_lock_i clears count_o to 0 at the next clock edge, and the current window restarts.
- R4: While crc4_en_i is low, count_o is 0 at every clock edge and frame strobes have no effect on it.
- R5: If a clear (lock or disable) and a window expiry fall in the same cycle, the clear wins and count_o becomes 0.
- R6: count_o saturates at 63: once there, a further expiry leaves it at 63.
- R7: status_o[7:3] equal count_o bits 5, 4, 3, 2 and 0, in that order (bit 7 = count bit 5, bit 3 = count bit 0). Count bit 1 does not appear in the byte.
- R8: status_o[2] follows crc4_srch_i, status_o[1] follows cas_srch_i and status_o[0] follows fas_srch_i in the same cycle, with no latching.
- R9: abandon_o is high exactly when count_o is 50 or more.
- R10: After reset, with all search inputs low, count_o is 0, abandon_o is 0 and status_o is 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_stb_i | input | 1 | One-cycle pulse per received frame |
| crc4_en_i | input | 1 | CRC-4 mode enable; low clears and holds the count |
| crc4_srch_i | input | 1 | Synchronizer is hunting for CRC-4 multiframe alignment |
| cas_srch_i | input | 1 | Synchronizer is hunting for CAS multiframe alignment |
| fas_srch_i | input | 1 | Synchronizer is hunting for frame alignment |
| crc4_lock_i | input | 1 | Pulse on reaching CRC-4 multiframe alignment |
| count_o | output | 6 | Number of expired search windows, saturating |
| status_o | output | 8 | Live status byte: packed count bits and search flags |
| abandon_o | output | 1 | High once count reaches 50 windows |

## Verification
A frame counter that is off by one moves the count increment forward or back by a whole strobe. This shows up at count_o at the edge after the 63rd or 65th strobe, instead of the 64th. A window that is not restarted when the search drops or a lock arrives gives an early increment within the next 64 strobes. A counter that wraps instead of saturating reads 0 one window after reaching 63. Any packing error shows in status_o in the same cycle, as soon as the count takes a value with a distinctive bit 1 or bit 0.

// File: rtl/crc4_sync_pkg.sv
`timescale 1ns/1ps
package crc4_sync_pkg;

  // Counter width is fixed by the status byte layout.
  localparam int CNT_W = 6;

  typedef logic [CNT_W-1:0] win_cnt_t;

  typedef struct packed {
    logic crc4;
    logic cas;
    logic fas;
  } srch_flags_t;

  // Bit 1 of the count is dropped to stretch range past 400 ms.
  function automatic logic [7:0] pack_status(input win_cnt_t c, input srch_flags_t f);
    return {c[5], c[4], c[3], c[2], c[0], f.crc4, f.cas, f.fas};
  endfunction

endpackage

// File: rtl/crc4_win_timer.sv
`timescale 1ns/1ps
module crc4_win_timer #(
  parameter int FRAMES_PER_WIN = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_stb_i,
  input  logic run_i,
  output logic expire_o
);

  localparam int FW = (FRAMES_PER_WIN > 1) ? $clog2(FRAMES_PER_WIN) : 1;
  localparam logic [FW-1:0] LAST = FW'(FRAMES_PER_WIN - 1);

  logic [FW-1:0] fcnt_q;

  assign expire_o = run_i && frame_stb_i && (fcnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q <= '0;
    end else if (!run_i) begin
      fcnt_q <= '0;
    end else if (frame_stb_i) begin
      fcnt_q <= (fcnt_q == LAST) ? '0 : fcnt_q + 1'b1;
    end
  end

  assert_win_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcnt_q <= LAST);

  assert_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> fcnt_q == '0);

  assert_expire_needs_run_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> run_i);

endmodule

// File: rtl/crc4_sat_cnt.sv
`timescale 1ns/1ps
module crc4_sat_cnt
  import crc4_sync_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     lock_i,
  input  logic     expire_i,
  output win_cnt_t cnt_o
);

  localparam win_cnt_t MAX = '1;

  win_cnt_t cnt_q;
  logic     clr;

  assign clr   = !en_i || lock_i;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;                    // clear beats increment
    end else if (expire_i && cnt_q != MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_lock_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> cnt_q == '0);

  assert_disable_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);

  assert_clear_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && lock_i) |=> cnt_q == '0);

  assert_no_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && en_i && !lock_i) |=> cnt_q == MAX);

  assert_step_only_on_expiry_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !lock_i && !expire_i) |=> $stable(cnt_q));

endmodule

// File: rtl/crc4_stat_pack.sv
`timescale 1ns/1ps
module crc4_stat_pack
  import crc4_sync_pkg::*;
(
  input  win_cnt_t    cnt_i,
  input  srch_flags_t flags_i,
  output logic [7:0]  status_o
);

  assign status_o = pack_status(cnt_i, flags_i);

endmodule

// File: rtl/crc4_sync_timer.sv
`timescale 1ns/1ps
module crc4_sync_timer
  import crc4_sync_pkg::*;
#(
  parameter int FRAMES_PER_WIN = 64,
  parameter int ABANDON_WINS   = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_stb_i,
  input  logic             crc4_en_i,
  input  logic             crc4_srch_i,
  input  logic             cas_srch_i,
  input  logic             fas_srch_i,
  input  logic             crc4_lock_i,
  output logic [CNT_W-1:0] count_o,
  output logic [7:0]       status_o,
  output logic             abandon_o
);

  localparam win_cnt_t ABANDON_AT = CNT_W'(ABANDON_WINS);

  logic        run;
  logic        expire;
  win_cnt_t    cnt;
  srch_flags_t flags;

  assign run   = crc4_en_i && crc4_srch_i && !crc4_lock_i;
  assign flags = '{crc4: crc4_srch_i, cas: cas_srch_i, fas: fas_srch_i};

  crc4_win_timer #(.FRAMES_PER_WIN(FRAMES_PER_WIN)) u_win_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_stb_i(frame_stb_i),
    .run_i      (run),
    .expire_o   (expire)
  );

  crc4_sat_cnt u_sat_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (crc4_en_i),
    .lock_i  (crc4_lock_i),
    .expire_i(expire),
    .cnt_o   (cnt)
  );

  crc4_stat_pack u_stat_pack (
    .cnt_i   (cnt),
    .flags_i (flags),
    .status_o(status_o)
  );

  assign count_o   = cnt;
  assign abandon_o = (cnt >= ABANDON_AT);

  assert_abandon_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abandon_o) |-> $past(expire));

  assert_count_moves_by_one_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != '0 && count_o != $past(count_o)) |-> count_o == $past(count_o) + 1'b1);

endmodule

// File: tb/crc4_sync_timer_bench.sv
`timescale 1ns/1ps
module crc4_sync_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0, en = 1'b0, srch = 1'b0, cas = 1'b0, fas = 1'b0, lock = 1'b0;
  logic [5:0] count;
  logic [7:0] status;
  logic       abandon;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  crc4_sync_timer u_crc4_sync_timer (
    .clk_i(clk), .rst_ni(rst_n), .frame_stb_i(stb), .crc4_en_i(en),
    .crc4_srch_i(srch), .cas_srch_i(cas), .fas_srch_i(fas), .crc4_lock_i(lock),
    .count_o(count), .status_o(status), .abandon_o(abandon)
  );

  function automatic logic [7:0] exp_status(input logic [5:0] c, input logic s, input logic a,
                                            input logic f);
    return {c[5], c[4], c[3], c[2], c[0], s, a, f};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) stb = 1'b1;
      @(negedge clk) stb = 1'b0;
    end
  endtask

  task automatic fresh_search;
    @(negedge clk) en = 1'b0; srch = 1'b0;
    @(negedge clk) en = 1'b1; srch = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R10 count", count, 0);
    check("R10 abandon", abandon, 0);
    check("R10 status", status, 0);
  endtask

  task automatic t_window;
    fresh_search();
    strobes(63);
    check("R1 63 strobes", count, 0);
    strobes(1);
    check("R1 64 strobes", count, 1);
    strobes(64);
    check("R1 second window", count, 2);
    check("R7 bit1 dropped", status, exp_status(6'd2, 1, 0, 0));
  endtask

  task automatic t_restart;
    fresh_search();
    strobes(40);
    @(negedge clk) srch = 1'b0;
    @(negedge clk) srch = 1'b1;
    strobes(40);
    check("R2 partial window discarded", count, 0);
    strobes(24);
    check("R2 window from search start", count, 1);
  endtask

  task automatic t_lock;
    fresh_search();
    strobes(128);
    check("R3 pre-lock", count, 2);
    @(negedge clk) lock = 1'b1;
    @(negedge clk) lock = 1'b0;
    check("R3 lock clears", count, 0);
    strobes(63);
    @(negedge clk) stb = 1'b1; lock = 1'b1;
    @(negedge clk) stb = 1'b0; lock = 1'b0;
    check("R5 lock beats expiry", count, 0);
    strobes(63);
    check("R3 window restarted by lock", count, 0);
    strobes(1);
    check("R3 expiry after restart", count, 1);
  endtask

  task automatic t_disable;
    fresh_search();
    strobes(64);
    check("R4 pre-disable", count, 1);
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    check("R4 disable clears", count, 0);
    strobes(70);
    check("R4 strobes ignored", count, 0);
    @(negedge clk) en = 1'b1;
    strobes(63);
    @(negedge clk) stb = 1'b1; en = 1'b0;
    @(negedge clk) stb = 1'b0;
    check("R5 disable beats expiry", count, 0);
    en = 1'b1;
  endtask

  task automatic t_flags;
    fresh_search();
    srch = 1'b0; cas = 1'b1; fas = 1'b0; #1;
    check("R8 cas flag", status, 8'h02);
    cas = 1'b0; fas = 1'b1; #1;
    check("R8 fas flag", status, 8'h01);
    srch = 1'b1; fas = 1'b0; #1;
    check("R8 crc4 flag", status, 8'h04);
    cas = 1'b1; fas = 1'b1; #1;
    check("R8 all flags", status, 8'h07);
    @(negedge clk) cas = 1'b0; fas = 1'b0;
  endtask

  task automatic t_saturate;
    fresh_search();
    strobes(64 * 49);
    check("R9 at 49", abandon, 0);
    check("R7 status at 49", status, exp_status(6'd49, 1, 0, 0));
    strobes(64);
    check("R9 count 50", count, 50);
    check("R9 at 50", abandon, 1);
    check("R7 status at 50", status, exp_status(6'd50, 1, 0, 0));
    strobes(64 * 13);
    check("R6 reach max", count, 63);
    check("R7 status at 63", status, 8'hFC);
    strobes(64);
    check("R6 saturates", count, 63);
    check("R9 still abandon", abandon, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window();
    t_restart();
    t_lock();
    t_disable();
    t_flags();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule